// File: doc/BRIEF.md
# Octal DAC Command Decoder and Register Bank

This block sits behind a serial receiver and turns complete 16-bit command words into the control state of an eight-channel voltage DAC. Each channel (A to H, index 0 to 7) owns a 10-bit staging register, a 10-bit live code that drives the converter, a powered-down flag and a termination choice for the powered-down output. A single global update mode decides whether a plain channel write reaches the live code at once or only stages it. The block also drives one bias-enable line for the shared analog circuitry.

A word is presented on `cmd_word` together with a one-cycle `cmd_valid` strobe. The whole command takes effect on that clock edge, so the outputs show the result one cycle after the strobe. Bit 15 picks between a channel write (0) and an opcode in bits 15:12 (1). Opcodes exist for the two update modes, a masked simultaneous update, a channel-A write that also refreshes every other channel, a broadcast write, and three power-down variants.

Top module: `octdac_ctrl`

## Requirements
- R1: With bit 15 at 0, bits 14:12 name the channel (0 = A … 7 = H) and bits 11:2 carry the code, which is stored in that channel's staging register; bits 1:0 have no effect. In register-only mode the live code does not change.
- R2: Opcode 1001 selects write-through mode, in which a channel write also loads the live code. Opcode 1000 returns to register-only mode. The mode persists until the other opcode is given.
- R3: Opcode 1010 copies the staging register into the live code, in the same cycle, for every channel whose bit is set in bits 7:0 (bit 0 = A, bit 7 = H). Channels with a clear bit keep their live code.
- R4: Opcode 1011 loads bits 11:2 into channel A's staging register and live code and copies every other channel's staging register to its live code. The update mode is left as it was.
- R5: Opcode 1100 loads bits 11:2 into all eight staging registers and all eight live codes.
- R6: Opcodes 1101, 1110 and 1111 power down the channels set in bits 7:0 with termination codes 1 (high impedance), 2 (100 kΩ to ground) and 3 (2.5 kΩ to ground). `pd_terms` reports 0 for a powered-up channel. Staging registers and live codes do not change.
- R7: A command that updates a channel's live code (write-through write, 1010, 1011 or 1100) clears that channel's powered-down flag and sets its termination to 0. A write that only stages a code leaves the power state alone.
- R8: `bias_en` is 0 exactly when all eight channels are powered down, and 1 otherwise.
- R9: After reset all live codes, staging registers, powered-down flags and terminations are 0, `bias_en` is 1 and the mode is register-only.
- R10: A word with `cmd_valid` low has no effect. A strobed command is visible on the outputs on the cycle after the strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Strobe: `cmd_word` is applied on this edge |
| cmd_word | input | CMD_W (16) | Command word |
| act_codes | output | NUM_CH*CODE_W (80) | Live codes, channel i at bits i*CODE_W +: CODE_W |
| pd_flags | output | NUM_CH (8) | Powered-down flag per channel, bit 0 = A |
| pd_terms | output | 2*NUM_CH (16) | Termination per channel, channel i at bits 2i +: 2 |
| bias_en | output | 1 | Low only when every channel is powered down |

## Verification
The bench builds the block with its default values: eight channels, 10-bit codes and 16-bit words. With these values every channel index and every mask bit is reachable. The all-channels-down case that drops `bias_en` can therefore be reached and then released again. The code field also spans exactly bits 11:2, so the ignored low bits can be driven to ones and checked to have no effect.

// File: rtl/octdac_pkg.sv
package octdac_pkg;

    localparam int DEF_NUM_CH = 8;
    localparam int DEF_CODE_W = 10;
    localparam int DEF_CMD_W  = 16;
    localparam int OP_W       = 4;
    localparam int CODE_LSB   = 2;

    typedef enum logic [1:0] {
        TERM_NONE = 2'd0,
        TERM_HIZ  = 2'd1,
        TERM_100K = 2'd2,
        TERM_2K5  = 2'd3
    } term_e;

    typedef enum logic [OP_W-1:0] {
        OP_SET_RO    = 4'h8,
        OP_SET_WT    = 4'h9,
        OP_SYNC_MASK = 4'hA,
        OP_A_AND_ALL = 4'hB,
        OP_BCAST     = 4'hC,
        OP_PD_HIZ    = 4'hD,
        OP_PD_100K   = 4'hE,
        OP_PD_2K5    = 4'hF
    } op_e;

    typedef enum logic {
        MODE_REG_ONLY   = 1'b0,
        MODE_WRITE_THRU = 1'b1
    } upd_mode_e;

    // Per-channel action for one cycle, produced by the decoder.
    typedef struct packed {
        logic  wr;    // load staging register from code field
        logic  load;  // load live code from code field
        logic  copy;  // load live code from staging register
        logic  pd;    // enter power-down
        term_e term;  // termination used with pd
    } ch_act_t;

    function automatic logic is_update(input ch_act_t a);
        return a.load | a.copy;
    endfunction

endpackage

// File: rtl/octdac_decode.sv
module octdac_decode
    import octdac_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W,
    parameter int CMD_W  = DEF_CMD_W
) (
    input  logic                    cmd_valid,
    input  logic [CMD_W-1:0]        cmd_word,
    input  upd_mode_e               mode_q,
    output ch_act_t [NUM_CH-1:0]    acts,
    output logic [CODE_W-1:0]       code,
    output logic                    mode_we,
    output upd_mode_e               mode_d
);
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam int OP_LSB = CMD_W - OP_W;

    logic [CH_W-1:0]   sel;
    logic [NUM_CH-1:0] mask;
    op_e               op;
    term_e             pd_term;

    always_comb begin
        code    = cmd_word[CODE_LSB +: CODE_W];
        sel     = cmd_word[OP_LSB +: CH_W];
        mask    = cmd_word[NUM_CH-1:0];
        op      = op_e'(cmd_word[CMD_W-1 -: OP_W]);
        pd_term = term_e'(cmd_word[OP_LSB +: 2]);
        mode_we = 1'b0;
        mode_d  = mode_q;
        for (int i = 0; i < NUM_CH; i++) begin
            acts[i] = '0;
        end
        if (cmd_valid) begin
            if (!cmd_word[CMD_W-1]) begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (sel == CH_W'(i)) begin
                        acts[i].wr   = 1'b1;
                        acts[i].load = (mode_q == MODE_WRITE_THRU);
                    end
                end
            end else begin
                case (op)
                    OP_SET_RO: begin
                        mode_we = 1'b1;
                        mode_d  = MODE_REG_ONLY;
                    end
                    OP_SET_WT: begin
                        mode_we = 1'b1;
                        mode_d  = MODE_WRITE_THRU;
                    end
                    OP_SYNC_MASK: begin
                        for (int i = 0; i < NUM_CH; i++) begin
                            acts[i].copy = mask[i];
                        end
                    end
                    OP_A_AND_ALL: begin
                        acts[0].wr   = 1'b1;
                        acts[0].load = 1'b1;
                        for (int i = 1; i < NUM_CH; i++) begin
                            acts[i].copy = 1'b1;
                        end
                    end
                    OP_BCAST: begin
                        for (int i = 0; i < NUM_CH; i++) begin
                            acts[i].wr   = 1'b1;
                            acts[i].load = 1'b1;
                        end
                    end
                    OP_PD_HIZ, OP_PD_100K, OP_PD_2K5: begin
                        for (int i = 0; i < NUM_CH; i++) begin
                            acts[i].pd   = mask[i];
                            acts[i].term = mask[i] ? pd_term : TERM_NONE;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/octdac_chan.sv
module octdac_chan
    import octdac_pkg::*;
#(
    parameter int CODE_W = DEF_CODE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  ch_act_t           act,
    input  logic [CODE_W-1:0] code,
    output logic [CODE_W-1:0] live_code,
    output logic              pd_flag,
    output term_e             term
);
    logic [CODE_W-1:0] stage_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q   <= '0;
            live_code <= '0;
            pd_flag   <= 1'b0;
            term      <= TERM_NONE;
        end else begin
            if (act.wr) begin
                stage_q <= code;
            end
            if (act.load) begin
                live_code <= code;
            end else if (act.copy) begin
                live_code <= stage_q;
            end
            if (is_update(act)) begin
                pd_flag <= 1'b0;
                term    <= TERM_NONE;
            end else if (act.pd) begin
                pd_flag <= 1'b1;
                term    <= act.term;
            end
        end
    end

endmodule

// File: rtl/octdac_ctrl.sv
module octdac_ctrl
    import octdac_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W,
    parameter int CMD_W  = DEF_CMD_W
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       cmd_valid,
    input  logic [CMD_W-1:0]           cmd_word,
    output logic [NUM_CH*CODE_W-1:0]   act_codes,
    output logic [NUM_CH-1:0]          pd_flags,
    output logic [2*NUM_CH-1:0]        pd_terms,
    output logic                       bias_en
);
    ch_act_t [NUM_CH-1:0] acts;
    logic [CODE_W-1:0]    code;
    logic                 mode_we;
    upd_mode_e            mode_d;
    upd_mode_e            mode_q;

    octdac_decode #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W),
        .CMD_W  (CMD_W)
    ) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .mode_q    (mode_q),
        .acts      (acts),
        .code      (code),
        .mode_we   (mode_we),
        .mode_d    (mode_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= MODE_REG_ONLY;
        end else if (mode_we) begin
            mode_q <= mode_d;
        end
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        term_e ch_term;

        octdac_chan #(
            .CODE_W (CODE_W)
        ) u_chan (
            .clk       (clk),
            .rst       (rst),
            .act       (acts[g]),
            .code      (code),
            .live_code (act_codes[g*CODE_W +: CODE_W]),
            .pd_flag   (pd_flags[g]),
            .term      (ch_term)
        );

        assign pd_terms[2*g +: 2] = ch_term;
    end

    assign bias_en = ~(&pd_flags);

endmodule

// File: rtl/octdac_ctrl_chk.sv
module octdac_ctrl_chk
    import octdac_pkg::*;
#(
    parameter int NUM_CH = DEF_NUM_CH,
    parameter int CODE_W = DEF_CODE_W,
    parameter int CMD_W  = DEF_CMD_W
) (
    input logic                     clk,
    input logic                     rst,
    input logic                     cmd_valid,
    input logic [CMD_W-1:0]         cmd_word,
    input logic [NUM_CH*CODE_W-1:0] act_codes,
    input logic [NUM_CH-1:0]        pd_flags,
    input logic [2*NUM_CH-1:0]      pd_terms,
    input logic                     bias_en
);
    logic [OP_W-1:0]   opc;
    logic [NUM_CH-1:0] msk;
    logic              is_pd;

    assign opc   = cmd_word[CMD_W-1 -: OP_W];
    assign msk   = cmd_word[NUM_CH-1:0];
    assign is_pd = cmd_valid && (opc >= 4'hD);

    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(act_codes) && $stable(pd_flags) && $stable(pd_terms));

    p_bcast_r5: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && opc == 4'hC |=>
            act_codes == {NUM_CH{$past(cmd_word[CODE_LSB +: CODE_W])}} && pd_flags == '0);

    p_pd_keep_r6: assert property (@(posedge clk) disable iff (rst)
        is_pd |=> $stable(act_codes) && ((pd_flags & $past(msk)) == $past(msk)));

    p_wake_r7: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && opc == 4'hA |=> (pd_flags & $past(msk)) == '0);

    p_all_down_r8: assert property (@(posedge clk) disable iff (rst)
        is_pd && ((msk | pd_flags) == '1) |=> !bias_en);

    p_bias_up_r8: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && opc == 4'hC |=> bias_en);

    p_mask_scope_r3: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && opc == 4'hA && !cmd_word[0] |=> $stable(act_codes[CODE_W-1:0]));

endmodule

bind octdac_ctrl octdac_ctrl_chk #(
    .NUM_CH (NUM_CH),
    .CODE_W (CODE_W),
    .CMD_W  (CMD_W)
) u_chk (.*);

// File: tb/octdac_ctrl_bench.sv
`timescale 1ns/1ps
module octdac_ctrl_bench;
    localparam int NCH = 8;
    localparam int CW  = 10;
    localparam int WD_CYCLES = 5000;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                cmd_valid = 1'b0;
    logic [15:0]         cmd_word = '0;
    logic [NCH*CW-1:0]   act_codes;
    logic [NCH-1:0]      pd_flags;
    logic [2*NCH-1:0]    pd_terms;
    logic                bias_en;

    int n_chk  = 0;
    int n_fail = 0;
    int exp_act  [NCH];
    int exp_pd   [NCH];
    int exp_term [NCH];

    always #5 clk = ~clk;

    octdac_ctrl u_octdac_ctrl (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .act_codes (act_codes),
        .pd_flags  (pd_flags),
        .pd_terms  (pd_terms),
        .bias_en   (bias_en)
    );

    function automatic logic [15:0] w_ch(input int ch, input logic [9:0] c, input logic [1:0] low);
        return {1'b0, 3'(ch), c, low};
    endfunction

    function automatic logic [15:0] w_op(input logic [3:0] op, input logic [11:0] arg);
        return {op, arg};
    endfunction

    task automatic chk(input string tag, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
        end
    endtask

    task automatic check_state(input string tag);
        int all_down = 1;
        for (int ch = 0; ch < NCH; ch++) begin
            chk($sformatf("%s code ch%0d", tag, ch), int'(act_codes[ch*CW +: CW]), exp_act[ch]);
            chk($sformatf("%s pd ch%0d", tag, ch), int'(pd_flags[ch]), exp_pd[ch]);
            chk($sformatf("%s term ch%0d", tag, ch), int'(pd_terms[2*ch +: 2]), exp_term[ch]);
            if (exp_pd[ch] == 0) all_down = 0;
        end
        chk({tag, " R8 bias"}, int'(bias_en), all_down ? 0 : 1);
    endtask

    // Strobe one word; returns at the next falling edge, one cycle later.
    task automatic send(input logic [15:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic t_reset;
        for (int ch = 0; ch < NCH; ch++) begin
            exp_act[ch] = 0; exp_pd[ch] = 0; exp_term[ch] = 0;
        end
        check_state("R9 reset");
    endtask

    task automatic t_reg_only;
        send(w_ch(2, 10'h155, 2'b11));
        check_state("R1 staged write");
        send(w_op(4'hA, 12'h004));
        exp_act[2] = 'h155;
        check_state("R1 low bits ignored");
    endtask

    task automatic t_idle;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = w_op(4'hC, {10'h3FF, 2'b00});
        repeat (3) @(negedge clk);
        check_state("R10 no strobe");
        cmd_word = '0;
    endtask

    task automatic t_write_thru;
        send(w_op(4'h9, 12'h000));
        send(w_ch(7, 10'h3FF, 2'b00));
        exp_act[7] = 'h3FF;
        check_state("R2 write-through");
        send(w_op(4'h8, 12'h000));
        send(w_ch(7, 10'h001, 2'b00));
        send(w_ch(1, 10'h0AA, 2'b00));
        check_state("R2 back to register-only");
    endtask

    task automatic t_masked;
        send(w_ch(3, 10'h111, 2'b00));
        send(w_ch(4, 10'h222, 2'b00));
        send(w_op(4'hA, 12'h018));
        exp_act[3] = 'h111;
        exp_act[4] = 'h222;
        check_state("R3 masked update");
    endtask

    task automatic t_chan_a;
        send(w_op(4'hB, {10'h2C3, 2'b00}));
        exp_act[0] = 'h2C3;
        exp_act[1] = 'h0AA;
        exp_act[7] = 'h001;
        check_state("R4 A write plus refresh");
        send(w_ch(5, 10'h050, 2'b00));
        check_state("R4 mode kept");
    endtask

    task automatic t_pd;
        send(w_op(4'hD, 12'h00F));
        for (int ch = 0; ch < 4; ch++) begin exp_pd[ch] = 1; exp_term[ch] = 1; end
        check_state("R6 hiz lower four");
        send(w_op(4'hE, 12'h0F0));
        for (int ch = 4; ch < NCH; ch++) begin exp_pd[ch] = 1; exp_term[ch] = 2; end
        check_state("R8 all down");
        send(w_op(4'hF, 12'h001));
        exp_term[0] = 3;
        check_state("R6 2k5 on A");
    endtask

    task automatic t_wake;
        send(w_op(4'hA, 12'h002));
        exp_pd[1] = 0; exp_term[1] = 0;
        check_state("R7 wake B");
        send(w_ch(2, 10'h077, 2'b00));
        check_state("R7 staged write keeps pd");
    endtask

    task automatic t_bcast;
        send(w_op(4'hC, {10'h3A5, 2'b00}));
        for (int ch = 0; ch < NCH; ch++) begin
            exp_act[ch] = 'h3A5; exp_pd[ch] = 0; exp_term[ch] = 0;
        end
        check_state("R5 broadcast");
        send(w_op(4'hA, 12'h0FF));
        check_state("R5 registers loaded");
        send(w_op(4'h9, 12'h000));
        send(w_ch(6, 10'h004, 2'b00));
        exp_act[6] = 'h004;
        check_state("R2 write-through on G");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reg_only();
        t_idle();
        t_write_thru();
        t_masked();
        t_chan_a();
        t_pd();
        t_wake();
        t_bcast();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(WD_CYCLES * 10);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule